// File: doc/BRIEF.md
# Programmable Waveform Playback Engine

This block plays a stored waveform out to a converter interface. A 1024-word by 16-bit sample table is loaded through a single write port. The same port sets three playback settings: how many table entries to play, a prescale divider and a speed divider. While playing, the engine emits one table word per output period together with a one-cycle strobe. The period is the product of the two dividers. The engine walks the table from address 0 upward.

A start pulse begins playback. It either makes one pass over the selected entries or loops over them until a halt pulse arrives. Out-of-range settings are forced into a legal range, so that no setting can stall the engine. Everything runs on one clock.

Top module: `wave_player`

## Requirements
- R1: A write with `cfg_sel`=0 stores `cfg_data` at table address `cfg_addr`. Playback emits the stored words in ascending address order starting at address 0.
- R2: A write with `cfg_sel`=1 sets the entry count. The value 0 is stored as 1, values above 1024 are stored as 1024, and playback covers addresses 0 to count-1.
- R3: A write with `cfg_sel`=2 sets the prescale divider. Values below 32 are stored as 32.
- R4: While busy, the first strobe comes prescale×speed cycles after the edge that accepted start, and each later strobe comes exactly prescale×speed cycles after the one before it.
- R5: When `loop_mode` is low at start, the engine emits count words and then stops. `busy` falls on the same edge that emits the last word.
- R6: When `loop_mode` is high at start, the engine wraps from count-1 back to address 0 and keeps going until halted.
- R7: A halt pulse clears `busy` and the strobe on the next edge, and no word is emitted afterwards. When halt and start arrive together, halt wins.
- R8: A write with `cfg_sel`=3 sets the speed divider. The value 0 is stored as 1.
- R9: A start accepted during playback restarts the walk at address 0 with both dividers cleared.
- R10: When a table write and the emission of the same address fall on the same edge, the word emitted is the one held before the write.
- R11: `sample_vld` is high for exactly one cycle per emitted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for table and settings |
| cfg_sel | input | 2 | Write target: 0 table, 1 count, 2 prescale, 3 speed |
| cfg_addr | input | 10 | Table address for table writes |
| cfg_data | input | 16 | Write data |
| start | input | 1 | Begin playback from address 0 |
| loop_mode | input | 1 | Loop when high at start, single pass when low |
| halt | input | 1 | Stop playback |
| sample_out | output | 16 | Last emitted table word |
| sample_vld | output | 1 | One-cycle strobe marking a new word |
| busy | output | 1 | High while playback runs |

## Verification
Two events can fall on the same edge: a table write and the emission of that same word. The bench provokes this by timing a write to address 0 so that it lands on the emission edge of a one-entry pass. It judges the result by requiring the old word at the output, and then the new word on the following pass. A second collision, start and halt in the same cycle, is driven while looping. It is judged by `busy` going low and no strobe appearing for the next several hundred cycles.

// File: rtl/wave_player.sv
`timescale 1ns/1ps
module wave_player #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 16,
  parameter int PRESCALE_MIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              start,
  input  logic              loop_mode,
  input  logic              halt,
  output logic [DATA_W-1:0] sample_out,
  output logic              sample_vld,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] prescale, speed, pre_cnt, spd_cnt;
  logic [ADDR_W-1:0] addr;
  logic              loop_q;

  wire [CNT_W-1:0] cnt_clamp =
    (cfg_data == '0) ? CNT_W'(1) :
    (32'(cfg_data) > DEPTH) ? CNT_W'(DEPTH) : CNT_W'(cfg_data);
  wire [DATA_W-1:0] pre_clamp =
    (32'(cfg_data) < PRESCALE_MIN) ? DATA_W'(PRESCALE_MIN) : cfg_data;
  wire [DATA_W-1:0] spd_clamp = (cfg_data == '0) ? DATA_W'(1) : cfg_data;

  wire pre_end = pre_cnt >= prescale - 1'b1;
  wire spd_end = spd_cnt >= speed - 1'b1;
  wire emit    = busy && pre_end && spd_end;
  wire last    = (CNT_W'(addr) + 1'b1) >= count;

  always_ff @(posedge clk)
    if (cfg_we && cfg_sel == 2'd0) mem[cfg_addr] <= cfg_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= CNT_W'(DEPTH);
      prescale <= DATA_W'(PRESCALE_MIN);
      speed    <= DATA_W'(1);
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd1:    count    <= cnt_clamp;
        2'd2:    prescale <= pre_clamp;
        2'd3:    speed    <= spd_clamp;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      loop_q     <= 1'b0;
      addr       <= '0;
      pre_cnt    <= '0;
      spd_cnt    <= '0;
      sample_vld <= 1'b0;
      sample_out <= '0;
    end else begin
      sample_vld <= 1'b0;
      if (halt) begin
        busy    <= 1'b0;
        addr    <= '0;
        pre_cnt <= '0;
        spd_cnt <= '0;
      end else if (start) begin
        busy    <= 1'b1;
        loop_q  <= loop_mode;
        addr    <= '0;
        pre_cnt <= '0;
        spd_cnt <= '0;
      end else if (busy) begin
        pre_cnt <= pre_end ? '0 : pre_cnt + 1'b1;
        if (pre_end) spd_cnt <= spd_end ? '0 : spd_cnt + 1'b1;
        if (emit) begin
          sample_vld <= 1'b1;
          sample_out <= mem[addr];
          if (last) begin
            addr <= '0;
            if (!loop_q) busy <= 1'b0;
          end else begin
            addr <= addr + 1'b1;
          end
        end
      end
    end
  end
endmodule

module wave_player_chk #(
  parameter int PRESCALE_MIN = 32
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic halt,
  input logic sample_vld,
  input logic busy
);
  logic [15:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || start || halt) gap <= '0;
    else if (sample_vld)         gap <= 16'd1;
    else if (gap != 16'hFFFF)    gap <= gap + 1'b1;
  end

  // R11
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);
  // R7
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!busy && !sample_vld));
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !halt) |=> busy);
  // R3
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (gap >= 16'(PRESCALE_MIN)));
  // R5
  vld_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> $past(busy));
endmodule

bind wave_player wave_player_chk #(.PRESCALE_MIN(PRESCALE_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
  .sample_vld(sample_vld), .busy(busy)
);

// File: tb/wave_player_test.sv
`timescale 1ns/1ps
module wave_player_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [9:0]  cfg_addr = 0;
  logic [15:0] cfg_data = 0;
  logic        start = 0, loop_mode = 0, halt = 0;
  logic [15:0] sample_out;
  logic        sample_vld, busy;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  wave_player uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .start(start), .loop_mode(loop_mode),
    .halt(halt), .sample_out(sample_out), .sample_vld(sample_vld), .busy(busy));

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, int a, logic [15:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_addr = 10'(a); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_vld) seen++;
    end
    chk(seen == 0 && !busy, req, seen, 0);
  endtask

  task automatic play(int cnt, int ps, bit lp, int nwatch, string req);
    int j = 0;
    int total = lp ? nwatch : cnt;
    loop_mode = lp; start = 1;
    @(negedge clk);
    start = 0; loop_mode = 0;
    for (int k = 1; k <= total * ps + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (sample_vld) begin
        chk(k == (j + 1) * ps + 1, {req, " R4 timing"}, k, (j + 1) * ps + 1);
        chk(sample_out == pat(j % cnt), {req, " R1 data"}, sample_out, pat(j % cnt));
        j++;
      end
    end
    chk(j == total, {req, " count"}, j, total);
    if (!lp) begin
      chk(!busy, {req, " R5 busy after pass"}, busy, 0);
      quiet(2 * ps, {req, " R5 stopped"});
    end else begin
      halt = 1;
      @(negedge clk);
      halt = 0;
      chk(!busy && !sample_vld, {req, " R7 halt"}, busy, 0);
      quiet(3 * ps, {req, " R7 silent"});
    end
  endtask

  initial begin
    #(5.0 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sample_vld && !busy && sample_out == 0, "reset", {sample_vld, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 1024; a++) wr(2'd0, a, pat(a));

    // R1 R2 R4 R5 R11: single-pass sweep
    wr(2'd2, 0, 16'd32);
    for (int s = 1; s <= 3; s++) begin
      wr(2'd3, 0, 16'(s));
      for (int c = 1; c <= 4; c++) begin
        wr(2'd1, 0, 16'(c));
        play(c, 32 * s, 0, 0, "R5 sweep");
      end
    end

    // R6 R7: loop wrap then halt
    wr(2'd1, 0, 16'd3); wr(2'd3, 0, 16'd2);
    play(3, 64, 1, 8, "R6 loop");

    // R3: prescale clamp
    wr(2'd2, 0, 16'd5); wr(2'd3, 0, 16'd1); wr(2'd1, 0, 16'd2);
    play(2, 32, 0, 0, "R3 clamp");

    // R8: speed zero treated as one
    wr(2'd2, 0, 16'd40); wr(2'd3, 0, 16'd0);
    play(2, 40, 0, 0, "R8 speed0");

    // R2: count clamps
    wr(2'd2, 0, 16'd32);
    wr(2'd1, 0, 16'd0);
    play(1, 32, 0, 0, "R2 count0");
    wr(2'd1, 0, 16'd2000);
    play(1024, 32, 0, 0, "R2 count max");

    // R9: restart mid-play
    wr(2'd1, 0, 16'd4);
    loop_mode = 1; start = 1;
    @(negedge clk);
    start = 0; loop_mode = 0;
    repeat (50) @(negedge clk);
    play(4, 32, 0, 0, "R9 restart");

    // R7: halt and start together
    loop_mode = 1; start = 1;
    @(negedge clk);
    start = 0; loop_mode = 0;
    repeat (40) @(negedge clk);
    halt = 1; start = 1;
    @(negedge clk);
    halt = 0; start = 0;
    chk(!busy, "R7 halt beats start", busy, 0);
    quiet(200, "R7 halt beats start silent");

    // R10: write on the emission edge of the same word
    wr(2'd1, 0, 16'd1);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (31) @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd0; cfg_addr = 0; cfg_data = 16'hBEEF;
    @(negedge clk);
    cfg_we = 0;
    chk(sample_vld && sample_out == pat(0), "R10 old word", sample_out, pat(0));
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (32) @(negedge clk);
    chk(sample_vld && sample_out == 16'hBEEF, "R10 new word", sample_out, 16'hBEEF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule